// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (SCL and SDA). It never drives the clock. It takes SCL as an input and drives SDA only through a pull-low enable, so the data line stays open-drain. A master reaches a 16-entry map of 8-bit registers through the block:

- Eight read/write control registers, presented in parallel to the logic they configure.
- Four read-only status registers, taken from an input vector.
- Four unused indices, which read as zero.

Both bus lines are oversampled in the system clock domain. START and STOP are detected on that sampled view. The full 7-bit slave address is a fixed upper nibble `0111` followed by three strap pins. The block takes those pins once only: at the seventh address bit of the first transfer seen on the bus, whatever device that transfer addresses. After that point the slave address is frozen.

A write transfer carries the slave address, then a register pointer byte, then data bytes. A read transfer, usually entered with a repeated START, returns bytes starting at the current pointer. The pointer advances by one after every data byte and wraps inside the 16-entry map.

Top module: `cfg_bus_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state, including inside a transfer (repeated START). A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Apart from these two events, the block changes its SDA drive only while SCL is low.
- R2: The slave address is {0111, pin2, pin1, pin0}, in the range 0x38 to 0x3F. The address byte is sent MSB first with the R/W bit last (1 = read). When the address matches, the block pulls SDA low during the ninth clock.
- R3: The three address pins are captured once, at the seventh address bit of the first transfer on the bus, even when that transfer addresses another device. Later changes on the pins do not change the address the block answers to.
- R4: After a non-matching address, the block gives no ACK and keeps SDA released for every later clock until the next START or STOP. Data bytes sent in that transfer are not written.
- R5: In a write transfer, the first byte after the address is the register pointer and is ACKed. Only its low four bits select the index (0x13 selects 0x03).
- R6: Each later byte of a write transfer is ACKed and stored in the read/write register at the pointer. Indices 0x00 to 0x07 are read/write. Register i appears on ctrl_o[8i+7:8i] after the STOP.
- R7: The pointer advances by one after every data byte, both written and read, and wraps from 0x0F to 0x00.
- R8: A read transfer returns the byte at the pointer, MSB first. Indices 0x00 to 0x07 return the control registers. Indices 0x08 to 0x0B return status_i byte (index − 8), where byte k is status_i[8k+7:8k]. Indices 0x0C to 0x0F return 0x00.
- R9: Writes to indices 0x08 to 0x0F are ACKed but change no register. ctrl_o keeps its value, and later reads still return the status bytes or 0x00.
- R10: In a read, the master's bit on the ninth clock is sampled. A NACK (SDA high) ends the transfer: the block keeps SDA released for all later clocks until the next START or STOP.
- R11: After reset, sda_oe_o is 0 and all control registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| sda_oe_o | output | 1 | Pull-low enable for SDA; 1 drives the line to 0 |
| addr_pins_i | input | 3 | Strap pins giving the low three slave address bits |
| status_i | input | 32 | Read-only status bytes for indices 0x08 to 0x0B |
| ctrl_o | output | 64 | Read/write control registers 0x00 to 0x07, byte i at [8i+7:8i] |

## Verification
The main faults to expect in this block are a wrong bit count, a wrong phase state or a stale pointer. A bit-count or phase fault is visible on SDA within the same byte: an ACK missing or misplaced on the ninth clock, or a read byte shifted by one bit. A pointer fault is silent in a write and shows only in a later read, as a byte taken from the wrong index, for example after a wrap or after a write to a read-only index. A fault in the address capture stays hidden until the strap pins change after the first transfer, so the bench moves them on purpose and then probes both the old and the new address.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_ACK_PRE,
    ST_ACK,
    ST_RDATA,
    ST_MACK_WAIT,
    ST_MACK,
    ST_IGNORE
  } bus_st_e;

endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe;
  logic [PIPE_W-1:0] sda_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign scl_d = scl_pipe[SYNC_STAGES];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign sda_d = sda_pipe[SYNC_STAGES];

  assign scl_lvl_o  = scl_s;
  assign sda_lvl_o  = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cbs_regbank.sv
module cbs_regbank #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 4,
  parameter int NUM_RW = 8,
  parameter int NUM_RO = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [PTR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [PTR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic [NUM_RO*DATA_W-1:0] status_i,
  output logic [NUM_RW*DATA_W-1:0] ctrl_o
);

  logic [DATA_W-1:0] rw_q [NUM_RW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RW; i++) rw_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_RW; i++) begin
        if (wr_addr_i == PTR_W'(i)) rw_q[i] <= wr_data_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : g_flat
    assign ctrl_o[g*DATA_W +: DATA_W] = rw_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (rd_addr_i == PTR_W'(i)) rd_data_o = rw_q[i];
    end
    for (int j = 0; j < NUM_RO; j++) begin
      if (rd_addr_i == PTR_W'(NUM_RW + j)) rd_data_o = status_i[j*DATA_W +: DATA_W];
    end
  end

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (int'(wr_addr_i) >= NUM_RW)) |=> $stable(ctrl_o)); // R9

endmodule

// File: rtl/cbs_bus_fsm.sv
module cbs_bus_fsm
  import cbs_pkg::*;
#(
  parameter int                      ADDR_W  = 7,
  parameter int                      PIN_W   = 3,
  parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI = 4'b0111,
  parameter int                      DATA_W  = 8,
  parameter int                      PTR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [PIN_W-1:0]  pins_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PIN_BIT  = CNT_W'(ADDR_W - 1);

  bus_st_e            state, nxt;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  shreg, tx;
  logic [PTR_W-1:0]   ptr;
  logic               locked;
  logic [PIN_W-1:0]   addr_lat;
  logic               sda_oe;
  logic               wr_en;
  logic [PTR_W-1:0]   wr_addr;
  logic [DATA_W-1:0]  wr_data;

  logic [DATA_W-1:0]  sh_next;
  logic               addr_hit;

  always_comb begin
    sh_next  = {shreg[DATA_W-2:0], sda_lvl_i};
    addr_hit = (sh_next[DATA_W-1:1] == {ADDR_HI, addr_lat});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      nxt      <= ST_REG;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      locked   <= 1'b0;
      addr_lat <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_i) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (rise_i) begin
            shreg <= sh_next;
            cnt   <= cnt + 1'b1;
            if (cnt == PIN_BIT && !locked) begin
              addr_lat <= pins_i;
              locked   <= 1'b1;
            end
            if (cnt == LAST_BIT) begin
              state <= addr_hit ? ST_ACK_PRE : ST_IGNORE;
              nxt   <= sh_next[0] ? ST_RDATA : ST_REG;
            end
          end
          ST_REG: if (rise_i) begin
            shreg <= sh_next;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              ptr   <= sh_next[PTR_W-1:0];
              state <= ST_ACK_PRE;
              nxt   <= ST_WDATA;
            end
          end
          ST_WDATA: if (rise_i) begin
            shreg <= sh_next;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= sh_next;
              ptr     <= ptr + 1'b1;
              state   <= ST_ACK_PRE;
              nxt     <= ST_WDATA;
            end
          end
          ST_ACK_PRE: if (fall_i) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (fall_i) begin
            cnt   <= '0;
            state <= nxt;
            if (nxt == ST_RDATA) begin
              tx     <= rd_data_i;
              sda_oe <= ~rd_data_i[DATA_W-1];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (rise_i) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                ptr   <= ptr + 1'b1;
                state <= ST_MACK_WAIT;
              end
            end else if (fall_i) begin
              tx     <= {tx[DATA_W-2:0], 1'b0};
              sda_oe <= ~tx[DATA_W-2];
            end
          end
          ST_MACK_WAIT: if (fall_i) begin
            sda_oe <= 1'b0;
            state  <= ST_MACK;
          end
          ST_MACK: if (rise_i) begin
            if (!sda_lvl_i) begin
              state <= ST_ACK;
              nxt   <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe;
  assign wr_en_o   = wr_en;
  assign wr_addr_o = wr_addr;
  assign wr_data_o = wr_data;
  assign rd_addr_o = ptr;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(addr_lat)); // R3

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ptr == PTR_W'(wr_addr + 1'b1))); // R7

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK && rise_i && sda_lvl_i && !start_i && !stop_i) |=> !sda_oe); // R10

endmodule

// File: rtl/cfg_bus_slave.sv
module cfg_bus_slave #(
  parameter int                      ADDR_W    = 7,
  parameter int                      PIN_W     = 3,
  parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI   = 4'b0111,
  parameter int                      DATA_W    = 8,
  parameter int                      MAP_DEPTH = 16,
  parameter int                      NUM_RW    = 8,
  parameter int                      NUM_RO    = 4,
  parameter int                      SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic [PIN_W-1:0]         addr_pins_i,
  input  logic [NUM_RO*DATA_W-1:0] status_i,
  output logic [NUM_RW*DATA_W-1:0] ctrl_o
);

  localparam int PTR_W = $clog2(MAP_DEPTH);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  cbs_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  cbs_bus_fsm #(
    .ADDR_W  (ADDR_W),
    .PIN_W   (PIN_W),
    .ADDR_HI (ADDR_HI),
    .DATA_W  (DATA_W),
    .PTR_W   (PTR_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .sda_lvl_i (sda_lvl),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .pins_i    (addr_pins_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  cbs_regbank #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .NUM_RW (NUM_RW),
    .NUM_RO (NUM_RO)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .status_i  (status_i),
    .ctrl_o    (ctrl_o)
  );

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe_o) && !$past(bus_start) && !$past(bus_stop)) |-> !$past(scl_lvl)); // R1

endmodule

// File: tb/cfg_bus_slave_tb_top.sv
module cfg_bus_slave_tb_top;

  localparam int Q  = 10;
  localparam int WD = 150000;
  localparam logic [31:0] STATUS = 32'hD4C3B2A1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mscl = 1'b1;
  logic msda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [2:0] pins = 3'b101;
  logic [63:0] ctrl;
  logic [63:0] exp_ctrl = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = msda & ~sda_oe;

  cfg_bus_slave dut_i (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (mscl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .addr_pins_i (pins),
    .status_i    (STATUS),
    .ctrl_o      (ctrl)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wq(); mscl = 1'b1; wq(); msda = 1'b0; wq(); mscl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq(); mscl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic write_bit(input logic b);
    msda = b; wq(); mscl = 1'b1; wq(); wq(); mscl = 1'b0; wq();
  endtask

  task automatic read_bit(output logic v);
    msda = 1'b1; wq(); mscl = 1'b1; wq(); v = sda_bus; wq(); mscl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(v);
    acked = ~v;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      read_bit(v);
      d[i] = v;
    end
    write_bit(~master_ack);
  endtask

  localparam logic [7:0] AW = 8'h7A;
  localparam logic [7:0] AR = 8'h7B;

  task automatic t_reset();
    chk("R11", "sda_oe after reset", {63'd0, sda_oe}, 64'd0);
    chk("R11", "ctrl after reset", ctrl, 64'd0);
  endtask

  task automatic t_lock();
    logic a;
    bus_start();
    write_byte(8'h60, a); chk("R4", "ack for 0x30", {63'd0, a}, 64'd0);
    write_byte(8'h00, a); chk("R4", "ack of ptr after miss", {63'd0, a}, 64'd0);
    write_byte(8'hEE, a); chk("R4", "ack of data after miss", {63'd0, a}, 64'd0);
    bus_stop();
    chk("R4", "ctrl after ignored write", ctrl, exp_ctrl);
    pins = 3'b010;
    wq();
    bus_start();
    write_byte(AW, a); chk("R3", "ack at frozen address 0x3D", {63'd0, a}, 64'd1);
    bus_stop();
    bus_start();
    write_byte(8'h74, a); chk("R3", "ack at new pin address 0x3A", {63'd0, a}, 64'd0);
    bus_stop();
  endtask

  task automatic t_write();
    logic a;
    bus_start();
    write_byte(AW, a); chk("R2", "address ack", {63'd0, a}, 64'd1);
    write_byte(8'h02, a); chk("R5", "pointer ack", {63'd0, a}, 64'd1);
    write_byte(8'hA5, a); chk("R6", "data ack 1", {63'd0, a}, 64'd1);
    write_byte(8'h3C, a); chk("R6", "data ack 2", {63'd0, a}, 64'd1);
    bus_stop();
    exp_ctrl[16 +: 8] = 8'hA5;
    exp_ctrl[24 +: 8] = 8'h3C;
    chk("R6", "ctrl after write", ctrl, exp_ctrl);
  endtask

  task automatic rd_seq(input logic [7:0] ptr, input int n, input logic [7:0] e0,
                        input logic [7:0] e1, input logic [7:0] e2, input string req);
    logic a;
    logic [7:0] d;
    logic [7:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    bus_start();
    write_byte(AW, a);
    write_byte(ptr, a);
    bus_start();
    write_byte(AR, a); chk("R1", "ack after repeated START", {63'd0, a}, 64'd1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d);
      chk(req, "read byte", {56'd0, d}, {56'd0, ex[k]});
    end
    bus_stop();
  endtask

  task automatic t_ptr_high();
    logic a;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h13, a);
    write_byte(8'h77, a);
    bus_stop();
    exp_ctrl[24 +: 8] = 8'h77;
    chk("R5", "upper pointer bits ignored", ctrl, exp_ctrl);
  endtask

  task automatic t_wrap();
    logic a;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h0F, a);
    write_byte(8'h11, a); chk("R9", "ack of write to 0x0F", {63'd0, a}, 64'd1);
    write_byte(8'h22, a);
    bus_stop();
    exp_ctrl[0 +: 8] = 8'h22;
    chk("R7", "write wrapped to 0x00", ctrl, exp_ctrl);
    rd_seq(8'h0F, 2, 8'h00, 8'h22, 8'h00, "R7");
  endtask

  task automatic t_ro();
    logic a;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h08, a);
    write_byte(8'hFF, a); chk("R9", "ack of write to 0x08", {63'd0, a}, 64'd1);
    bus_stop();
    chk("R9", "ctrl after read-only write", ctrl, exp_ctrl);
    rd_seq(8'h08, 1, STATUS[7:0], 8'h00, 8'h00, "R9");
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] d;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h00, a);
    bus_start();
    write_byte(AR, a);
    read_byte(1'b0, d);
    chk("R10", "last byte before NACK", {56'd0, d}, 64'h22);
    read_byte(1'b0, d);
    chk("R10", "bus released after NACK", {56'd0, d}, 64'hFF);
    bus_stop();
    bus_start();
    write_byte(AR, a);
    read_byte(1'b0, d);
    chk("R7", "read ptr advanced to 0x01", {56'd0, d}, {56'd0, exp_ctrl[8 +: 8]});
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_lock();
    t_write();
    rd_seq(8'h02, 2, 8'hA5, 8'h3C, 8'h00, "R8");
    t_ptr_high();
    t_wrap();
    t_ro();
    rd_seq(8'h0A, 3, STATUS[23:16], STATUS[31:24], 8'h00, "R8");
    t_nack();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule